// File: doc/BRIEF.md
# Four-Level Priority Request Queue

This block is the intake stage of a multi-channel transfer engine. Several requestors share one request bus, and each presents a transfer descriptor with a valid/ready handshake. The bus takes at most one descriptor per cycle. When several requestors compete, the most urgent level wins. The accepted descriptor is registered once and then written into the FIFO that belongs to its priority level. There are four levels: 0 is the most urgent and 3 the least.

Each FIFO feeds one register set of its own. A register set holds the live source address, destination address and remaining element count of a single transfer. A register set takes the head of its FIFO only while it is idle, so each level runs one transfer at a time, and the four levels run in parallel. The data mover outside the block pulses a per-level step input for each element it moves. The register set then updates its addresses by the descriptor's address mode and decrements its count. When the count reaches zero, the register set goes idle and pulses a done flag on its own level.

Top module: `prq_top`

## Requirements
- R1: After synchronous reset, every slot_busy and slot_done bit is 0, and every slot_src, slot_dst and slot_cnt field reads 0.
- R2: Each requestor's descriptor is DESC_W=102 bits, packed from the least significant bit upward: src[31:0], dst[63:32], count[79:64], stride[95:80], dst mode[97:96], src mode[99:98], level[101:100]. At most one req_ready bit is high in any cycle.
- R3: Among requestors with req_valid high whose level has room, the lowest level number is granted. Ties at one level go to the lowest requestor index. req_ready is high only for the granted requestor, in the same cycle.
- R4: A level whose accepted-but-unloaded descriptors number DEPTH (16) grants no requestor at that level, and it does not block grants at other levels.
- R5: A descriptor accepted at clock edge k is written to its FIFO at edge k+1. If its level is idle with an empty FIFO, it is loaded at edge k+2, and slot_busy rises then.
- R6: A level's register set loads a descriptor only while it is idle. Descriptors of one level load in the order they were accepted.
- R7: Register sets of different levels may be busy at the same time.
- R8: On each xfer_step of a busy level with nonzero count, the source and destination addresses each update by their own mode: 0 keeps the address, 1 adds 1, 2 subtracts 1, 3 adds the sign-extended 16-bit stride. The address arithmetic wraps modulo 2^32.
- R9: Each such step decrements slot_cnt by one. The step that brings the count to zero also clears slot_busy and raises slot_done for exactly one cycle. xfer_step on an idle level has no effect.
- R10: A descriptor with count 0 is loaded, then retired at the next edge with a one-cycle slot_done, whether or not a step is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Per-requestor descriptor valid |
| req_ready | output | NREQ | Per-requestor grant; the descriptor is taken when valid and ready are both high |
| req_desc | input | NREQ*DESC_W | Descriptors, requestor r at bits [r*DESC_W +: DESC_W] |
| xfer_step | input | 4 | Per-level pulse: one element moved |
| slot_busy | output | 4 | Per-level register set holds an active transfer |
| slot_src | output | 4*32 | Per-level current source address |
| slot_dst | output | 4*32 | Per-level current destination address |
| slot_cnt | output | 4*16 | Per-level remaining element count |
| slot_done | output | 4 | Per-level one-cycle completion pulse |

## Verification
req_ready is combinational, so the bench compares it against a reference arbitration in the same cycle, a moment after the inputs settle. The register-set outputs change one edge after the step or load that causes them. A fresh descriptor shows up as slot_busy two edges after its acceptance edge, and a zero-count descriptor's slot_done comes one edge after its load. The reference model advances once per clock edge, using the inputs that were applied during the cycle that just ended. Every output is compared at the following falling edge, and the directed cases test these exact edge counts.

// File: rtl/prq_pkg.sv
package prq_pkg;
  parameter int ADDR_W   = 32;
  parameter int CNT_W    = 16;
  parameter int STRIDE_W = 16;
  parameter int NLEVEL   = 4;
  localparam int LVL_W   = $clog2(NLEVEL);

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_INDEX = 2'd3
  } amode_e;

  typedef struct packed {
    amode_e                smode;
    amode_e                dmode;
    logic [STRIDE_W-1:0]   stride;
    logic [CNT_W-1:0]      count;
    logic [ADDR_W-1:0]     dst;
    logic [ADDR_W-1:0]     src;
  } xfer_body_t;

  typedef struct packed {
    logic [LVL_W-1:0] level;
    xfer_body_t       body;
  } xfer_desc_t;

  localparam int BODY_W = $bits(xfer_body_t);
  localparam int DESC_W = $bits(xfer_desc_t);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input amode_e m,
                                                  input logic [STRIDE_W-1:0] s);
    case (m)
      AM_INC:   return a + ADDR_W'(1);
      AM_DEC:   return a - ADDR_W'(1);
      AM_INDEX: return a + {{(ADDR_W-STRIDE_W){s[STRIDE_W-1]}}, s};
      default:  return a;
    endcase
  endfunction
endpackage

// File: rtl/prq_bus_arb.sv
module prq_bus_arb
  import prq_pkg::*;
#(
  parameter int NREQ = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREQ-1:0]   req_valid,
  input  xfer_desc_t        req_desc [NREQ],
  input  logic [NLEVEL-1:0] room,
  output logic [NREQ-1:0]   req_ready,
  output logic              acc_vld,
  output logic [LVL_W-1:0]  acc_level,
  output logic              stg_vld,
  output xfer_desc_t        stg_desc
);
  xfer_desc_t win_desc;
  logic       found;

  always_comb begin
    req_ready = '0;
    found     = 1'b0;
    win_desc  = '0;
    for (int lv = 0; lv < NLEVEL; lv++) begin
      for (int r = 0; r < NREQ; r++) begin
        if (!found && req_valid[r] && room[lv] &&
            req_desc[r].level == LVL_W'(lv)) begin
          found        = 1'b1;
          req_ready[r] = 1'b1;
          win_desc     = req_desc[r];
        end
      end
    end
  end

  assign acc_vld   = found;
  assign acc_level = win_desc.level;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_vld  <= 1'b0;
      stg_desc <= '0;
    end else begin
      stg_vld <= found;
      if (found) stg_desc <= win_desc;
    end
  end

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));
  assert_stage_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (|(req_ready & req_valid)) |=> stg_vld);
  assert_no_grant_full_R4: assert property (@(posedge clk) disable iff (rst)
    acc_vld |-> room[acc_level]);
endmodule

// File: rtl/prq_fifo.sv
module prq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (wr) wp <= wp + PW'(1);
      if (rd) rp <= rp + PW'(1);
      case ({wr, rd})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign rdata = mem[rp];
  assign empty = (fill == '0);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    wr |-> (fill < CW'(DEPTH)) || rd);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    rd |-> !empty);
endmodule

// File: rtl/prq_slot.sv
module prq_slot
  import prq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  xfer_body_t        ldesc,
  input  logic              step,
  output logic              busy,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [CNT_W-1:0]  cnt,
  output logic              done
);
  amode_e              smode, dmode;
  logic [STRIDE_W-1:0] stride;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      src    <= '0;
      dst    <= '0;
      cnt    <= '0;
      smode  <= AM_FIXED;
      dmode  <= AM_FIXED;
      stride <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load) begin
          busy   <= 1'b1;
          src    <= ldesc.src;
          dst    <= ldesc.dst;
          cnt    <= ldesc.count;
          smode  <= ldesc.smode;
          dmode  <= ldesc.dmode;
          stride <= ldesc.stride;
        end
      end else if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (step) begin
        src <= step_addr(src, smode, stride);
        dst <= step_addr(dst, dmode, stride);
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_hold_count_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !step && cnt != '0) |=> busy && $stable(cnt));
  assert_idle_ignores_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> $stable(src) && $stable(dst) && !busy);
  assert_load_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(load));
endmodule

// File: rtl/prq_top.sv
module prq_top
  import prq_pkg::*;
#(
  parameter int NREQ  = 3,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREQ-1:0]          req_valid,
  output logic [NREQ-1:0]          req_ready,
  input  logic [NREQ*DESC_W-1:0]   req_desc,
  input  logic [NLEVEL-1:0]        xfer_step,
  output logic [NLEVEL-1:0]        slot_busy,
  output logic [NLEVEL*ADDR_W-1:0] slot_src,
  output logic [NLEVEL*ADDR_W-1:0] slot_dst,
  output logic [NLEVEL*CNT_W-1:0]  slot_cnt,
  output logic [NLEVEL-1:0]        slot_done
);
  localparam int CRW = $clog2(DEPTH + 1);

  xfer_desc_t        desc_arr [NREQ];
  logic [NLEVEL-1:0] room;
  logic              acc_vld, stg_vld;
  logic [LVL_W-1:0]  acc_level;
  xfer_desc_t        stg_desc;

  for (genvar r = 0; r < NREQ; r++) begin : g_unpack
    assign desc_arr[r] = req_desc[r*DESC_W +: DESC_W];
  end

  prq_bus_arb #(.NREQ(NREQ)) u_arb (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_desc(desc_arr),
    .room(room), .req_ready(req_ready), .acc_vld(acc_vld),
    .acc_level(acc_level), .stg_vld(stg_vld), .stg_desc(stg_desc)
  );

  for (genvar lv = 0; lv < NLEVEL; lv++) begin : g_level
    logic [CRW-1:0]    cred;
    logic              push, pop, empty, busy;
    logic              inc;
    xfer_body_t        head;
    logic [ADDR_W-1:0] s_src, s_dst;
    logic [CNT_W-1:0]  s_cnt;

    assign push = stg_vld && (stg_desc.level == LVL_W'(lv));
    assign pop  = !busy && !empty;
    assign inc  = acc_vld && (acc_level == LVL_W'(lv));
    assign room[lv] = (cred != CRW'(DEPTH));

    always_ff @(posedge clk) begin
      if (rst) cred <= '0;
      else begin
        case ({inc, pop})
          2'b10:   cred <= cred + CRW'(1);
          2'b01:   cred <= cred - CRW'(1);
          default: cred <= cred;
        endcase
      end
    end

    prq_fifo #(.W(BODY_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .wr(push), .wdata(stg_desc.body),
      .rd(pop), .rdata(head), .empty(empty)
    );

    prq_slot u_slot (
      .clk(clk), .rst(rst), .load(pop), .ldesc(head), .step(xfer_step[lv]),
      .busy(busy), .src(s_src), .dst(s_dst), .cnt(s_cnt), .done(slot_done[lv])
    );

    assign slot_busy[lv]                 = busy;
    assign slot_src[lv*ADDR_W +: ADDR_W] = s_src;
    assign slot_dst[lv*ADDR_W +: ADDR_W] = s_dst;
    assign slot_cnt[lv*CNT_W +: CNT_W]   = s_cnt;

    assert_credit_bound_R4: assert property (@(posedge clk) disable iff (rst)
      cred <= CRW'(DEPTH));
    assert_pop_needs_credit_R6: assert property (@(posedge clk) disable iff (rst)
      pop |-> cred != '0);
  end
endmodule

// File: tb/sim_prq_top.sv
module sim_prq_top;
  import prq_pkg::*;
  localparam int NREQ = 3, DEPTH = 16, NL = NLEVEL;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                  rst;
  logic [NREQ-1:0]       req_valid, req_ready;
  logic [NREQ*DESC_W-1:0] req_desc;
  logic [NL-1:0]         step, busy, done;
  logic [NL*ADDR_W-1:0]  src, dst;
  logic [NL*CNT_W-1:0]   cnt;
  xfer_desc_t            d_in [NREQ];

  always_comb for (int r = 0; r < NREQ; r++) req_desc[r*DESC_W +: DESC_W] = d_in[r];

  prq_top #(.NREQ(NREQ), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_desc(req_desc), .xfer_step(step), .slot_busy(busy), .slot_src(src),
    .slot_dst(dst), .slot_cnt(cnt), .slot_done(done)
  );

  int checks = 0, fails = 0;
  xfer_body_t mq [NL][$];
  bit         stg_v;
  xfer_desc_t stg_d;
  int         cred [NL];
  bit         mb [NL], mdn [NL];
  logic [ADDR_W-1:0] ms [NL], md [NL];
  logic [CNT_W-1:0]  mc [NL];
  xfer_body_t        mcur [NL];
  int last_win;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] ref_addr(input logic [ADDR_W-1:0] a, input amode_e m,
                                                 input logic [STRIDE_W-1:0] s);
    logic [ADDR_W-1:0] delta;
    delta = '0;
    if (m == AM_INC) delta = 1;
    else if (m == AM_DEC) delta = '1;
    else if (m == AM_INDEX) delta = ADDR_W'($signed(s));
    return a + delta;
  endfunction

  function automatic int exp_winner();
    for (int lv = 0; lv < NL; lv++)
      for (int r = 0; r < NREQ; r++)
        if (req_valid[r] && d_in[r].level == LVL_W'(lv) && cred[lv] < DEPTH) return r;
    return -1;
  endfunction

  function automatic xfer_desc_t rand_desc(input int lvl, input int minc);
    xfer_desc_t d;
    d.level       = (lvl < 0) ? LVL_W'($urandom % NL) : LVL_W'(lvl);
    d.body.smode  = amode_e'($urandom % 4);
    d.body.dmode  = amode_e'($urandom % 4);
    d.body.stride = STRIDE_W'($urandom);
    d.body.count  = CNT_W'(minc + ($urandom % 5));
    d.body.dst    = $urandom;
    d.body.src    = $urandom;
    return d;
  endfunction

  task automatic cycle();
    int w;
    #1;
    w = exp_winner();
    last_win = w;
    for (int r = 0; r < NREQ; r++)
      chk(req_ready[r] == (w == r), "R3 R4 grant", 64'(req_ready), 64'(w));
    chk($countones(req_ready) <= 1, "R2 single grant", 64'(req_ready), 64'(1));
    @(posedge clk);
    @(negedge clk);
    for (int lv = 0; lv < NL; lv++) begin
      mdn[lv] = 0;
      if (!mb[lv]) begin
        if (mq[lv].size() > 0) begin
          mcur[lv] = mq[lv].pop_front();
          mb[lv] = 1; ms[lv] = mcur[lv].src; md[lv] = mcur[lv].dst; mc[lv] = mcur[lv].count;
          cred[lv]--;
        end
      end else if (mc[lv] == 0) begin
        mb[lv] = 0; mdn[lv] = 1;
      end else if (step[lv]) begin
        ms[lv] = ref_addr(ms[lv], mcur[lv].smode, mcur[lv].stride);
        md[lv] = ref_addr(md[lv], mcur[lv].dmode, mcur[lv].stride);
        mc[lv] = mc[lv] - 1;
        if (mc[lv] == 0) begin mb[lv] = 0; mdn[lv] = 1; end
      end
    end
    if (stg_v) mq[stg_d.level].push_back(stg_d.body);
    stg_v = (w >= 0);
    if (w >= 0) begin stg_d = d_in[w]; cred[d_in[w].level]++; end
    for (int lv = 0; lv < NL; lv++) begin
      chk(busy[lv] == mb[lv], "R6 busy", 64'(busy[lv]), 64'(mb[lv]));
      chk(done[lv] == mdn[lv], "R9 done", 64'(done[lv]), 64'(mdn[lv]));
      chk(src[lv*ADDR_W +: ADDR_W] == ms[lv], "R8 src", 64'(src[lv*ADDR_W +: ADDR_W]), 64'(ms[lv]));
      chk(dst[lv*ADDR_W +: ADDR_W] == md[lv], "R8 dst", 64'(dst[lv*ADDR_W +: ADDR_W]), 64'(md[lv]));
      chk(cnt[lv*CNT_W +: CNT_W] == mc[lv], "R9 count", 64'(cnt[lv*CNT_W +: CNT_W]), 64'(mc[lv]));
    end
  endtask

  task automatic quiet(input int n, input logic [NL-1:0] st);
    req_valid = '0;
    step = st;
    repeat (n) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int acc3;
    void'($urandom(32'd4242));
    rst = 1'b1; req_valid = '0; step = '0;
    for (int r = 0; r < NREQ; r++) d_in[r] = '0;
    stg_v = 0; stg_d = '0;
    for (int lv = 0; lv < NL; lv++) begin
      cred[lv] = 0; mb[lv] = 0; mdn[lv] = 0; ms[lv] = '0; md[lv] = '0; mc[lv] = '0; mcur[lv] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(busy == '0 && done == '0, "R1 flags", 64'({busy, done}), 64'(0));
    chk(src == '0 && dst == '0 && cnt == '0, "R1 fields", 64'(cnt), 64'(0));

    // R5: acceptance to load latency
    d_in[0] = rand_desc(1, 2);
    req_valid = 3'b001;
    cycle();
    req_valid = '0;
    cycle();
    chk(busy[1] == 1'b0, "R5 not loaded at k+1", 64'(busy[1]), 64'(0));
    cycle();
    chk(busy[1] == 1'b1, "R5 loaded at k+2", 64'(busy[1]), 64'(1));
    quiet(10, '1);

    // R10: zero count retires one edge after load without steps
    d_in[1] = rand_desc(2, 0);
    d_in[1].body.count = '0;
    req_valid = 3'b010; step = '0;
    cycle();
    req_valid = '0;
    cycle(); cycle();
    chk(busy[2] == 1'b1 && cnt[2*CNT_W +: CNT_W] == '0, "R10 loaded zero", 64'(busy[2]), 64'(1));
    cycle();
    chk(done[2] == 1'b1 && busy[2] == 1'b0, "R10 done pulse", 64'({busy[2], done[2]}), 64'(1));
    cycle();
    chk(done[2] == 1'b0, "R10 pulse one cycle", 64'(done[2]), 64'(0));

    // R3: same-cycle requests, levels 2,0,0 -> requestor 1
    d_in[0] = rand_desc(2, 1); d_in[1] = rand_desc(0, 1); d_in[2] = rand_desc(0, 1);
    req_valid = 3'b111;
    #1;
    chk(req_ready == 3'b010, "R3 urgent lowest index", 64'(req_ready), 64'(2));
    cycle();
    req_valid = 3'b101;
    cycle();
    req_valid = 3'b001;
    cycle();
    // R7: levels 0 and 2 active together
    quiet(2, '0);
    chk(busy[0] && busy[2], "R7 concurrent", 64'(busy), 64'(5));
    quiet(30, '1);

    // R4: fill level 3 with no steps
    acc3 = 0;
    step = '0;
    for (int i = 0; i < 24; i++) begin
      d_in[0] = rand_desc(3, 1);
      req_valid = 3'b001;
      cycle();
      if (last_win == 0) acc3++;
    end
    chk(acc3 == DEPTH + 1, "R4 level full count", 64'(acc3), 64'(DEPTH + 1));
    d_in[2] = rand_desc(1, 1);
    req_valid = 3'b101;
    #1;
    chk(req_ready == 3'b100, "R4 other level unaffected", 64'(req_ready), 64'(4));
    cycle();
    req_valid = '0;
    for (int i = 0; i < 200; i++) begin
      step = NL'($urandom);
      cycle();
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      for (int r = 0; r < NREQ; r++) d_in[r] = rand_desc(-1, 0);
      req_valid = NREQ'($urandom);
      step = NL'($urandom | $urandom);
      cycle();
    end
    quiet(300, '1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule